// File: doc/BRIEF.md
# Logarithmic Rotate and Shift Unit

This block performs logical shifts, an arithmetic right shift and rotates in both directions on a 64-bit integer operand. The amount can come from a register or an immediate, because the block only sees a 6-bit amount. The datapath is a chain of six stages, and each stage moves the value by a fixed power of two (1, 2, 4, 8, 16, 32). One bit of the amount enables each stage. A rotate uses the same chain as a shift: the bits that leave one end of a stage enter at the other end, instead of a fill value.

The core only moves bits to the right. A left operation reverses the bit order of the operand before the chain and reverses the result after it.

A word mode serves 32-bit operations on a 64-bit datapath. In word mode:
- only the low 32 operand bits and the low 5 amount bits matter;
- the 32-bit result is sign-extended to 64 bits.

The result is registered once, so it appears one clock after the inputs are sampled.

Top module: `shf_unit`

## Requirements
- R1: While rst_n is low, result_o is 0.
- R2: result_o shows the result for the inputs sampled at the previous rising clock edge, and does not change between edges.
- R3: With kind_i = 2'b00 and dir_right_i = 0 (logical left), the operand moves toward bit 63 by the amount and zeros enter at bit 0.
- R4: With kind_i = 2'b00 and dir_right_i = 1 (logical right), the operand moves toward bit 0 and zeros enter at the top.
- R5: With kind_i = 2'b01 and dir_right_i = 1 (arithmetic right), copies of the sign bit enter at the top. The sign bit is bit 63, or bit 31 in word mode.
- R6: With kind_i = 2'b01 and dir_right_i = 0, the result equals the logical left shift.
- R7: With kind_i = 2'b10 and dir_right_i = 0 (rotate left), bits leaving the top re-enter at bit 0.
- R8: With kind_i = 2'b10 and dir_right_i = 1 (rotate right), bits leaving bit 0 re-enter at the top. A rotate right by n equals a rotate left by (64 - n) mod 64.
- R9: kind_i = 2'b11 behaves exactly as kind_i = 2'b10.
- R10: In full mode all 6 amount bits are used. In word mode amount_i[5] is ignored.
- R11: With word_i = 1, operand bits 63..32 are ignored, the operation acts on a 32-bit value, and result bits 63..32 copy result bit 31.
- R12: A rotate by an amount of zero returns the operand unchanged.
- R13: A full-mode rotate keeps the number of set bits of the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| operand_i | input | 64 | Value to shift or rotate |
| amount_i | input | 6 | Shift or rotate distance |
| dir_right_i | input | 1 | 1 = toward bit 0, 0 = toward the top |
| kind_i | input | 2 | 00 logical, 01 arithmetic, 10/11 rotate |
| word_i | input | 1 | 32-bit word mode with sign-extended result |
| result_o | output | 64 | Registered result |

## Verification
The assertions compare the registered result with the inputs held one edge earlier. For this, they require the inputs to be stable around the rising edge. The bench meets this by changing the inputs only on falling edges.

The assertions only fire after one real edge out of reset, so they never compare against inputs sampled during reset. The stimulus covers:
- every amount from 0 to 63 for each operation, in both modes;
- word-mode amounts with bit 5 set;
- operands whose upper half is random in word mode, so the ignored bits actually vary.

// File: rtl/shf_pkg.sv
package shf_pkg;
    localparam int XLEN_DEF = 64;
    localparam int WLEN_DEF = 32;

    typedef enum logic [1:0] {
        KIND_LOGIC   = 2'b00,
        KIND_ARITH   = 2'b01,
        KIND_ROT     = 2'b10,
        KIND_ROT_ALT = 2'b11
    } shf_kind_e;
endpackage

// File: rtl/shf_prep.sv
module shf_prep #(
    parameter int XLEN  = shf_pkg::XLEN_DEF,
    parameter int WLEN  = shf_pkg::WLEN_DEF,
    parameter int AMT_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]  operand_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic             dir_right_i,
    input  logic [1:0]       kind_i,
    input  logic             word_i,
    output logic [XLEN-1:0]  core_o,
    output logic [AMT_W-1:0] amt_o,
    output logic             rotate_o,
    output logic             arith_o
);
    localparam int REPS = XLEN / WLEN;
    localparam logic [AMT_W-1:0] FULL_MASK = AMT_W'(XLEN - 1);
    localparam logic [AMT_W-1:0] WORD_MASK = AMT_W'(WLEN - 1);

    logic [XLEN-1:0] framed;

    always_comb begin
        rotate_o = kind_i[1];
        arith_o  = (kind_i == shf_pkg::KIND_ARITH) && dir_right_i;
        amt_o    = amount_i & (word_i ? WORD_MASK : FULL_MASK);

        if (!word_i) begin
            framed = operand_i;
        end else if (rotate_o) begin
            framed = {REPS{operand_i[WLEN-1:0]}};
        end else if (arith_o) begin
            framed = {{(XLEN-WLEN){operand_i[WLEN-1]}}, operand_i[WLEN-1:0]};
        end else begin
            framed = {{(XLEN-WLEN){1'b0}}, operand_i[WLEN-1:0]};
        end

        for (int i = 0; i < XLEN; i++) begin
            core_o[i] = dir_right_i ? framed[i] : framed[XLEN-1-i];
        end
    end
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
    parameter int W     = shf_pkg::XLEN_DEF,
    parameter int SHIFT = 1
) (
    input  logic [W-1:0] data_i,
    input  logic         en_i,
    input  logic         rotate_i,
    input  logic         arith_i,
    output logic [W-1:0] data_o
);
    logic [SHIFT-1:0] fill;

    always_comb begin
        fill   = rotate_i ? data_i[SHIFT-1:0] : {SHIFT{arith_i & data_i[W-1]}};
        data_o = en_i ? {fill, data_i[W-1:SHIFT]} : data_i;
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
    parameter int XLEN = shf_pkg::XLEN_DEF,
    parameter int WLEN = shf_pkg::WLEN_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [XLEN-1:0]         operand_i,
    input  logic [$clog2(XLEN)-1:0] amount_i,
    input  logic                    dir_right_i,
    input  logic [1:0]              kind_i,
    input  logic                    word_i,
    output logic [XLEN-1:0]         result_o
);
    localparam int AMT_W = $clog2(XLEN);

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            seen;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0]  core_in;
    logic [AMT_W-1:0] amt_eff;
    logic             rotate;
    logic             arith;
    logic [XLEN-1:0]  chain [AMT_W+1];

    shf_prep #(.XLEN(XLEN), .WLEN(WLEN), .AMT_W(AMT_W)) u_prep (
        .operand_i  (operand_i),
        .amount_i   (amount_i),
        .dir_right_i(dir_right_i),
        .kind_i     (kind_i),
        .word_i     (word_i),
        .core_o     (core_in),
        .amt_o      (amt_eff),
        .rotate_o   (rotate),
        .arith_o    (arith)
    );

    assign chain[0] = core_in;

    for (genvar g = 0; g < AMT_W; g++) begin : g_stage
        shf_stage #(.W(XLEN), .SHIFT(1 << g)) u_stage (
            .data_i  (chain[g]),
            .en_i    (amt_eff[g]),
            .rotate_i(rotate),
            .arith_i (arith),
            .data_o  (chain[g+1])
        );
    end

    logic [XLEN-1:0] unrev;

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            unrev[i] = dir_right_i ? chain[AMT_W][i] : chain[AMT_W][XLEN-1-i];
        end
        st_d.seen   = 1'b1;
        st_d.result = word_i ? {{(XLEN-WLEN){unrev[WLEN-1]}}, unrev[WLEN-1:0]} : unrev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;

    AST_ROT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen && $past(kind_i[1]) && !$past(word_i) && ($past(amount_i) == '0)
        |-> result_o == $past(operand_i)); // R12
    AST_ROT_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen && $past(kind_i[1]) && !$past(word_i)
        |-> $countones(result_o) == $countones($past(operand_i))); // R13
    AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen && $past(word_i)
        |-> result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}}); // R11
    AST_SHL_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen && ($past(kind_i) == 2'b00) && !$past(dir_right_i) && !$past(word_i)
        && ($past(amount_i) != '0) |-> result_o[0] == 1'b0); // R3
    AST_SHR_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen && ($past(kind_i) == 2'b00) && $past(dir_right_i) && !$past(word_i)
        && ($past(amount_i) != '0) |-> result_o[XLEN-1] == 1'b0); // R4
endmodule

// File: tb/shf_unit_test.sv
module shf_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand_i = '0;
    logic [5:0]  amount_i = '0;
    logic        dir_right_i = 1'b0;
    logic [1:0]  kind_i = 2'b00;
    logic        word_i = 1'b0;
    logic [63:0] result_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    shf_unit uut (
        .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .amount_i(amount_i),
        .dir_right_i(dir_right_i), .kind_i(kind_i), .word_i(word_i), .result_o(result_o)
    );

    function automatic logic [63:0] model(input logic [63:0] x, input int amt,
                                          input logic right, input logic [1:0] kind,
                                          input logic word);
        logic [31:0] x32, r32;
        int n;
        if (word) begin
            n   = amt % 32;
            x32 = x[31:0];
            if (kind[1])
                r32 = right ? ((x32 >> n) | (x32 << (32 - n))) : ((x32 << n) | (x32 >> (32 - n)));
            else if (right && kind == 2'b01)
                r32 = 32'($signed(x32) >>> n);
            else if (right)
                r32 = x32 >> n;
            else
                r32 = x32 << n;
            return {{32{r32[31]}}, r32};
        end
        n = amt % 64;
        if (kind[1])
            return right ? ((x >> n) | (x << (64 - n))) : ((x << n) | (x >> (64 - n)));
        if (right && kind == 2'b01)
            return 64'($signed(x) >>> n);
        return right ? (x >> n) : (x << n);
    endfunction

    function automatic string tag_of(input logic right, input logic [1:0] kind, input logic word);
        if (word) return "R11";
        case (kind)
            2'b00: return right ? "R4" : "R3";
            2'b01: return right ? "R5" : "R6";
            2'b10: return right ? "R8" : "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [63:0] x, input int amt, input logic right,
                         input logic [1:0] kind, input logic word);
        @(negedge clk);
        operand_i   = x;
        amount_i    = 6'(amt);
        dir_right_i = right;
        kind_i      = kind;
        word_i      = word;
        @(negedge clk);
    endtask

    task automatic run(input logic [63:0] x, input int amt, input logic right,
                       input logic [1:0] kind, input logic word);
        drive(x, amt, right, kind, word);
        check(tag_of(right, kind, word), result_o, model(x, amt, right, kind, word));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] pats [4];
        logic [63:0] a, b;

        pats[0] = 64'h8000_0000_0000_0001;
        pats[1] = 64'hF0E1_D2C3_B4A5_9687;
        pats[2] = {$urandom, $urandom};
        pats[3] = {$urandom, $urandom};

        // R1: reset value
        operand_i = 64'hFFFF_FFFF_FFFF_FFFF;
        kind_i    = 2'b10;
        repeat (3) @(negedge clk);
        check("R1", result_o, 64'h0);
        rst_n = 1'b1;

        // R2: output holds until the next rising edge
        drive(64'h1234, 4, 1'b0, 2'b00, 1'b0);
        operand_i = 64'h5;
        amount_i  = 6'd1;
        #3;
        check("R2", result_o, 64'h12340);
        @(negedge clk);
        check("R2", result_o, 64'hA);

        // R3..R9, R11: every operation, every amount
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int n = 0; n < 64; n++) begin
                            run(pats[p], n, d[0], 2'(k), w[0]);
                        end
                    end
                end
            end
        end

        // R8: rotate right n equals rotate left (64 - n) mod 64
        for (int n = 0; n < 64; n++) begin
            drive(pats[1], n, 1'b1, 2'b10, 1'b0);
            a = result_o;
            drive(pats[1], (64 - n) % 64, 1'b0, 2'b10, 1'b0);
            b = result_o;
            check("R8", a, b);
        end

        // R10: word mode ignores amount bit 5
        for (int n = 0; n < 32; n++) begin
            drive(pats[2], n, 1'b1, 2'b01, 1'b1);
            a = result_o;
            drive(pats[2], n + 32, 1'b1, 2'b01, 1'b1);
            check("R10", result_o, a);
        end

        // R10: full mode uses amount bit 5
        drive(64'h1, 32, 1'b0, 2'b00, 1'b0);
        check("R10", result_o, 64'h1_0000_0000);

        // R11: upper operand bits ignored in word mode
        drive(64'hFFFF_FFFF_0000_0001, 31, 1'b0, 2'b00, 1'b1);
        check("R11", result_o, 64'hFFFF_FFFF_8000_0000);
        drive(64'h0000_0000_8000_0000, 4, 1'b1, 2'b01, 1'b1);
        check("R5", result_o, 64'hFFFF_FFFF_F800_0000);

        // R12: rotate by zero
        drive(pats[3], 0, 1'b1, 2'b11, 1'b0);
        check("R12", result_o, pats[3]);
        drive(pats[3], 0, 1'b0, 2'b10, 1'b0);
        check("R12", result_o, pats[3]);

        // R13: rotate keeps the number of set bits
        drive(pats[2], 23, 1'b1, 2'b10, 1'b0);
        check("R13", 64'($countones(result_o)), 64'($countones(pats[2])));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule